// File: doc/BRIEF.md
# Configuration Precedence Merge

This block produces the single set of settings an Ethernet controller runs with. Three sources feed it. Pin straps give the base personality and are captured while reset is held. A nonvolatile store is delivered as a stream of 16-bit words and ends with a done strobe that carries a checksum verdict. Runtime writes from the driver form the third source. Each field takes its value from the highest source that marks it valid. Driver overrides rank above stored values, and stored values rank above straps.

The merged outputs cover the host interface mode (0 = RGMII, 1 = SGMII), the transmit and receive clock-delay enables, the SGMII auto-negotiation and in-band status policies, wake-on-LAN enable, a 2-bit LED mode and the 48-bit MAC address. The latched straps, the store load status and the per-source valid masks can each be read back on their own. A counter records each reset epoch in which the effective settings depart from the strap defaults. An interface-mode change is held back until the data path reports idle.

Top module: `cfg_precedence_merge`

## Requirements
- R1: Each field takes the driver value when its driver-valid bit is set. Otherwise it takes the stored value when its store-valid bit is set. Otherwise it takes the latched strap value. The selection is made per field, so one source can supply some fields while another supplies the rest.
- R2: The strap inputs are captured on every cycle in which hard reset (rst_n) or soft reset (soft_rst_n) is low. After both resets are released, rb_strap and the strap-derived outputs ignore any change on strap_i.
- R3: Stored fields take effect only at nvm_done, when nvm_crc_ok is high and exactly four words have arrived since nvm_start. Word 0 holds the valid mask in bits [7:0], with mask bit i belonging to field code i. Word 0 bits [15:8] hold the small fields: bit 8 interface mode, bit 9 tx delay, bit 10 rx delay, bit 11 auto-negotiation, bit 12 in-band status, bit 13 WOL, bits [15:14] LED mode. Words 1, 2 and 3 carry MAC bits [15:0], [31:16] and [47:32]. Before the done strobe the outputs do not change.
- R4: A load that ends with a bad checksum or a word count other than four discards all stored fields, including any from an earlier good load, and sets a sticky error flag. Only hard reset clears that flag.
- R5: A driver write (drv_wr) sets the value of the field selected by drv_fsel, LSB-aligned in drv_wdata, and marks that field valid. A driver clear (drv_clr) drops the field's override, and the field then falls back to the lower source. The field codes are 0 interface mode, 1 tx delay, 2 rx delay, 3 auto-negotiation, 4 in-band status, 5 WOL, 6 LED mode, 7 MAC address.
- R6: Driver overrides survive a soft reset and are cleared by a hard reset. Stored fields and load status are cleared by both kinds of reset.
- R7: While dp_idle is low, eff_if_mode holds its value and apply_pending is high whenever the merged mode differs from it. The new mode is applied on the first clock edge with dp_idle high, and apply_pending then drops.
- R8: mismatch_cnt increments at most once per reset epoch, on the first cycle in which the effective settings differ from the latched straps. The count saturates at all-ones, survives a soft reset and clears on a hard reset.
- R9: rb_nvm_status reads {error, checksum-ok, count-ok} from the last load. rb_nvm_mask and rb_drv_mask read the valid bits of each source, indexed by field code.
- R10: For unchanged straps and an unchanged stored image, eff_mac after a soft reset and reload equals its value before the reset. A driver MAC override keeps its value across a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst_n | input | 1 | Soft reset, synchronous, active low |
| strap_i | input | 56 | Strap pins in merged field layout |
| nvm_start | input | 1 | Begin a store load |
| nvm_wvalid | input | 1 | Store word valid |
| nvm_wdata | input | 16 | Store word |
| nvm_done | input | 1 | End of store load |
| nvm_crc_ok | input | 1 | Checksum verdict, sampled with nvm_done |
| drv_wr | input | 1 | Driver override write |
| drv_clr | input | 1 | Driver override clear |
| drv_fsel | input | 3 | Field code for write or clear |
| drv_wdata | input | 48 | Override value, LSB-aligned |
| dp_idle | input | 1 | Data path idle, permits mode change |
| eff_if_mode | output | 1 | Effective interface mode |
| eff_tx_dly | output | 1 | Effective tx delay enable |
| eff_rx_dly | output | 1 | Effective rx delay enable |
| eff_an_en | output | 1 | Effective auto-negotiation enable |
| eff_ibs_en | output | 1 | Effective in-band status enable |
| eff_wol_en | output | 1 | Effective wake-on-LAN enable |
| eff_led | output | 2 | Effective LED mode |
| eff_mac | output | 48 | Effective MAC address |
| apply_pending | output | 1 | Mode change waiting for idle |
| rb_strap | output | 56 | Latched strap readback |
| rb_nvm_status | output | 3 | {error, checksum-ok, count-ok} |
| rb_nvm_mask | output | 8 | Store valid bits per field |
| rb_drv_mask | output | 8 | Driver valid bits per field |
| mismatch_cnt | output | CNT_W | Epochs that departed from straps |

## Verification
The merge is exercised with overlapping valid masks in several combinations. These include a store image that sets values for fields its mask leaves invalid, a driver override placed over a stored MAC and then cleared, and a driver mode override written while the data path is busy. Together they separate correct per-field priority from whole-word selection, and they show that a stale value is not leaked through. Bad-checksum, short and good loads are issued one after another, which distinguishes discarding all stored data from partial application and confirms that the error flag stays set. Repeated soft resets and a final hard reset separate what each kind of reset preserves, drive the mismatch counter into saturation, and confirm that the MAC comes back identical.

// File: rtl/cfgm_pkg.sv
// Shared constants for the configuration merge. The merged vector is laid out
// with bit 0 interface mode, 1 tx delay, 2 rx delay, 3 auto-negotiation,
// 4 in-band status, 5 WOL, then LED mode, then MAC address. Field code i
// (driver select and valid masks) refers to the i-th field of that list.
package cfgm_pkg;
    localparam int LED_W     = 2;
    localparam int MAC_W     = 48;
    localparam int NFIELD    = 8;
    localparam int FSEL_W    = $clog2(NFIELD);
    localparam int SMALL_W   = 6 + LED_W;
    localparam int CFG_W     = SMALL_W + MAC_W;
    localparam int WORD_W    = 16;
    localparam int NVM_WORDS = (NFIELD + CFG_W + WORD_W - 1) / WORD_W;
    localparam int IMG_W     = NVM_WORDS * WORD_W;
    localparam int STAT_W    = 3;
    localparam int FLD_LSB [NFIELD] = '{0, 1, 2, 3, 4, 5, 6, 6 + LED_W};
    localparam int FLD_W   [NFIELD] = '{1, 1, 1, 1, 1, 1, LED_W, MAC_W};

    typedef enum logic [FSEL_W-1:0] {
        F_IFM, F_TXD, F_RXD, F_AN, F_IBS, F_WOL, F_LED, F_MAC
    } fld_e;
endpackage

// File: rtl/cfgm_strap_latch.sv
// Captures the strap pins while either reset is held and keeps them frozen
// afterwards. Assumes the strap pins are stable during the reset window.
module cfgm_strap_latch
    import cfgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_n,
    input  logic [CFG_W-1:0] strap_i,
    output logic [CFG_W-1:0] strap_q
);
    // Sample straps throughout any reset, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) begin
            strap_q <= strap_i;
        end
    end

    // Straps stay frozen once both resets are released.
    assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_n && $past(soft_rst_n)) |-> $stable(strap_q));
endmodule

// File: rtl/cfgm_nvm_loader.sv
// Assembles the store word stream into a staging image and commits it at the
// done strobe, only when the checksum is good and the word count is exact.
// A failed load discards every stored field and sets a sticky error flag.
// Assumes nvm_start precedes the words and nvm_done follows the last one.
module cfgm_nvm_loader
    import cfgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              nvm_start,
    input  logic              nvm_wvalid,
    input  logic [WORD_W-1:0] nvm_wdata,
    input  logic              nvm_done,
    input  logic              nvm_crc_ok,
    output logic [CFG_W-1:0]  nvm_val,
    output logic [NFIELD-1:0] nvm_mask,
    output logic              load_ok,
    output logic              crc_ok_q,
    output logic              nvm_err
);
    localparam int IDX_W  = $clog2(NVM_WORDS);
    localparam int WIDX_W = $clog2(NVM_WORDS + 1) + 1;

    logic [WIDX_W-1:0] widx;
    logic [IMG_W-1:0]  img;
    logic              cnt_ok;
    logic              good;

    assign cnt_ok = (widx == WIDX_W'(NVM_WORDS));
    assign good   = cnt_ok && nvm_crc_ok;

    // Collect incoming words into the staging image and count them.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n || nvm_start) begin
            widx <= '0;
            img  <= '0;
        end else if (nvm_wvalid) begin
            if (widx < WIDX_W'(NVM_WORDS)) begin
                img[widx[IDX_W-1:0] * WORD_W +: WORD_W] <= nvm_wdata;
            end
            if (widx != '1) begin
                widx <= widx + 1'b1;
            end
        end
    end

    // Commit or discard the image at the done strobe and record status.
    always_ff @(posedge clk) begin
        if (!rst_n || !soft_rst_n) begin
            nvm_val  <= '0;
            nvm_mask <= '0;
            load_ok  <= 1'b0;
            crc_ok_q <= 1'b0;
        end else if (nvm_done) begin
            load_ok  <= cnt_ok;
            crc_ok_q <= nvm_crc_ok;
            if (good) begin
                nvm_val  <= img[NFIELD +: CFG_W];
                nvm_mask <= img[NFIELD-1:0];
            end else begin
                nvm_val  <= '0;
                nvm_mask <= '0;
            end
        end
    end

    // Sticky error flag, cleared by hard reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nvm_err <= 1'b0;
        end else if (nvm_done && !good) begin
            nvm_err <= 1'b1;
        end
    end

    // Any stored field in effect implies a complete, checksum-clean load.
    assert_nvm_valid_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_mask != '0) |-> (load_ok && crc_ok_q));
    // The error flag never drops while hard reset is released.
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        nvm_err |=> nvm_err);
    // A bad checksum at done leaves no stored field valid.
    assert_bad_crc_discards_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nvm_done && !nvm_crc_ok) |=> (nvm_mask == '0));
endmodule

// File: rtl/cfgm_drv_override.sv
// Holds the driver override value and valid bit for every field. Only hard
// reset clears them, so they persist across soft reset.
module cfgm_drv_override
    import cfgm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_wr,
    input  logic              drv_clr,
    input  logic [FSEL_W-1:0] drv_fsel,
    input  logic [MAC_W-1:0]  drv_wdata,
    output logic [CFG_W-1:0]  drv_val,
    output logic [NFIELD-1:0] drv_mask
);
    for (genvar i = 0; i < NFIELD; i++) begin : g_fld
        logic [FLD_W[i]-1:0] val_r;
        logic                vld_r;
        logic                sel;

        assign sel = (drv_fsel == FSEL_W'(i));

        // Per-field override storage: write sets, clear drops the valid bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_r <= '0;
                vld_r <= 1'b0;
            end else if (drv_wr && sel) begin
                val_r <= drv_wdata[FLD_W[i]-1:0];
                vld_r <= 1'b1;
            end else if (drv_clr && sel) begin
                vld_r <= 1'b0;
            end
        end

        assign drv_val[FLD_LSB[i] +: FLD_W[i]] = val_r;
        assign drv_mask[i] = vld_r;
    end
endmodule

// File: rtl/cfg_precedence_merge.sv
// Top of the configuration merge. Selects each field from driver, store or
// strap in that priority, gates interface-mode changes on data-path idle,
// and counts reset epochs whose effective settings depart from the straps.
// Assumes resets are synchronous and held for at least one clock edge.
module cfg_precedence_merge
    import cfgm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic [CFG_W-1:0]  strap_i,
    input  logic              nvm_start,
    input  logic              nvm_wvalid,
    input  logic [WORD_W-1:0] nvm_wdata,
    input  logic              nvm_done,
    input  logic              nvm_crc_ok,
    input  logic              drv_wr,
    input  logic              drv_clr,
    input  logic [FSEL_W-1:0] drv_fsel,
    input  logic [MAC_W-1:0]  drv_wdata,
    input  logic              dp_idle,
    output logic              eff_if_mode,
    output logic              eff_tx_dly,
    output logic              eff_rx_dly,
    output logic              eff_an_en,
    output logic              eff_ibs_en,
    output logic              eff_wol_en,
    output logic [LED_W-1:0]  eff_led,
    output logic [MAC_W-1:0]  eff_mac,
    output logic              apply_pending,
    output logic [CFG_W-1:0]  rb_strap,
    output logic [STAT_W-1:0] rb_nvm_status,
    output logic [NFIELD-1:0] rb_nvm_mask,
    output logic [NFIELD-1:0] rb_drv_mask,
    output logic [CNT_W-1:0]  mismatch_cnt
);
    localparam int IFM = FLD_LSB[F_IFM];

    logic [CFG_W-1:0]  strap_q, nvm_val, drv_val, cand, eff_vec;
    logic [NFIELD-1:0] nvm_mask, drv_mask;
    logic              load_ok, crc_ok_q, nvm_err;
    logic              ifm_q, seen_q;
    logic              in_rst;

    assign in_rst = !rst_n || !soft_rst_n;

    cfgm_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .strap_i(strap_i), .strap_q(strap_q)
    );

    cfgm_nvm_loader u_nvm (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
        .nvm_start(nvm_start), .nvm_wvalid(nvm_wvalid), .nvm_wdata(nvm_wdata),
        .nvm_done(nvm_done), .nvm_crc_ok(nvm_crc_ok),
        .nvm_val(nvm_val), .nvm_mask(nvm_mask),
        .load_ok(load_ok), .crc_ok_q(crc_ok_q), .nvm_err(nvm_err)
    );

    cfgm_drv_override u_drv (
        .clk(clk), .rst_n(rst_n),
        .drv_wr(drv_wr), .drv_clr(drv_clr), .drv_fsel(drv_fsel),
        .drv_wdata(drv_wdata), .drv_val(drv_val), .drv_mask(drv_mask)
    );

    // Per-field priority select: driver over store over strap.
    for (genvar i = 0; i < NFIELD; i++) begin : g_pick
        assign cand[FLD_LSB[i] +: FLD_W[i]] =
            drv_mask[i] ? drv_val[FLD_LSB[i] +: FLD_W[i]] :
            nvm_mask[i] ? nvm_val[FLD_LSB[i] +: FLD_W[i]] :
                          strap_q[FLD_LSB[i] +: FLD_W[i]];
    end

    // Interface mode register: loaded in reset, updated only on data-path idle.
    always_ff @(posedge clk) begin
        if (in_rst) begin
            ifm_q <= drv_mask[F_IFM] ? drv_val[IFM] : strap_i[IFM];
        end else if (dp_idle) begin
            ifm_q <= cand[IFM];
        end
    end

    assign eff_vec = {cand[CFG_W-1:IFM+1], ifm_q};

    // Count once per reset epoch when effective settings leave strap defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mismatch_cnt <= '0;
            seen_q       <= 1'b0;
        end else if (!soft_rst_n) begin
            seen_q <= 1'b0;
        end else if (!seen_q && (eff_vec != strap_q)) begin
            seen_q <= 1'b1;
            if (mismatch_cnt != {CNT_W{1'b1}}) begin
                mismatch_cnt <= mismatch_cnt + 1'b1;
            end
        end
    end

    assign eff_if_mode   = ifm_q;
    assign eff_tx_dly    = cand[FLD_LSB[F_TXD]];
    assign eff_rx_dly    = cand[FLD_LSB[F_RXD]];
    assign eff_an_en     = cand[FLD_LSB[F_AN]];
    assign eff_ibs_en    = cand[FLD_LSB[F_IBS]];
    assign eff_wol_en    = cand[FLD_LSB[F_WOL]];
    assign eff_led       = cand[FLD_LSB[F_LED] +: LED_W];
    assign eff_mac       = cand[FLD_LSB[F_MAC] +: MAC_W];
    assign apply_pending = (cand[IFM] != ifm_q);
    assign rb_strap      = strap_q;
    assign rb_nvm_status = {nvm_err, crc_ok_q, load_ok};
    assign rb_nvm_mask   = nvm_mask;
    assign rb_drv_mask   = drv_mask;

    // Mode output holds across any busy cycle outside reset.
    assert_mode_held_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_n && !dp_idle) |=> $stable(eff_if_mode));
    // Driver overrides survive a soft reset cycle with no driver access.
    assert_drv_kept_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst_n && !drv_wr && !drv_clr) |=> $stable(rb_drv_mask));
    // Mismatch counter only ever steps up by one.
    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_cnt != $past(mismatch_cnt)) |-> (mismatch_cnt == $past(mismatch_cnt) + 1'b1));
endmodule

// File: tb/tb_cfg_precedence_merge.sv
module tb_cfg_precedence_merge;
    import cfgm_pkg::*;

    localparam int CW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0, soft_rst_n = 1'b1;
    logic [CFG_W-1:0]  strap_i = '0;
    logic              nvm_start = 0, nvm_wvalid = 0, nvm_done = 0, nvm_crc_ok = 0;
    logic [WORD_W-1:0] nvm_wdata = '0;
    logic              drv_wr = 0, drv_clr = 0, dp_idle = 1;
    logic [FSEL_W-1:0] drv_fsel = '0;
    logic [MAC_W-1:0]  drv_wdata = '0;
    logic              eff_if_mode, eff_tx_dly, eff_rx_dly, eff_an_en, eff_ibs_en, eff_wol_en;
    logic [LED_W-1:0]  eff_led;
    logic [MAC_W-1:0]  eff_mac;
    logic              apply_pending;
    logic [CFG_W-1:0]  rb_strap;
    logic [STAT_W-1:0] rb_nvm_status;
    logic [NFIELD-1:0] rb_nvm_mask, rb_drv_mask;
    logic [CW-1:0]     mismatch_cnt;

    cfg_precedence_merge #(.CNT_W(CW)) dut (.*);

    typedef struct { string req; int kind; logic [63:0] exp; } item_t;
    item_t q[$];
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // Reference model state
    logic [CFG_W-1:0]  m_strap, m_nvm, m_drv;
    logic [NFIELD-1:0] m_nmask, m_dmask;

    function automatic logic [CFG_W-1:0] mk(logic [47:0] mac, logic [1:0] led, logic wol,
                                            logic ibs, logic an, logic rxd, logic txd, logic ifm);
        return {mac, led, wol, ibs, an, rxd, txd, ifm};
    endfunction

    function automatic logic [CFG_W-1:0] model_eff();
        logic [CFG_W-1:0] r;
        for (int f = 0; f < NFIELD; f++)
            for (int b = FLD_LSB[f]; b < FLD_LSB[f] + FLD_W[f]; b++)
                r[b] = m_dmask[f] ? m_drv[b] : (m_nmask[f] ? m_nvm[b] : m_strap[b]);
        return r;
    endfunction

    function automatic logic [63:0] observe(int kind);
        case (kind)
            0: return 64'({eff_mac, eff_led, eff_wol_en, eff_ibs_en, eff_an_en,
                           eff_rx_dly, eff_tx_dly, eff_if_mode});
            1: return 64'(rb_strap);
            2: return 64'(rb_nvm_status);
            3: return 64'(rb_nvm_mask);
            4: return 64'(rb_drv_mask);
            5: return 64'(mismatch_cnt);
            6: return 64'(apply_pending);
            7: return 64'(eff_if_mode);
            default: return 64'(eff_mac);
        endcase
    endfunction

    task automatic expect_item(string req, int kind, logic [63:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        q.push_back(it);
    endtask

    // Monitor: compares queued expectations between clock edges
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [63:0] got;
            it = q.pop_front();
            got = observe(it.kind);
            n_chk++;
            if (got !== it.exp) begin
                n_err++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic hard_reset(logic [CFG_W-1:0] s);
        strap_i = s; rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        step();
        m_strap = s; m_nmask = '0; m_nvm = '0; m_dmask = '0; m_drv = '0;
    endtask

    task automatic soft_reset(logic [CFG_W-1:0] s);
        strap_i = s; soft_rst_n = 0;
        repeat (3) step();
        soft_rst_n = 1;
        step();
        m_strap = s; m_nmask = '0; m_nvm = '0;
    endtask

    task automatic nvm_load(logic [NFIELD-1:0] mask, logic [CFG_W-1:0] img, int nw, bit crc);
        logic [IMG_W-1:0] words;
        words = {img, mask};
        nvm_start = 1; step(); nvm_start = 0;
        for (int i = 0; i < nw; i++) begin
            nvm_wvalid = 1; nvm_wdata = words[i*WORD_W +: WORD_W]; step();
        end
        nvm_wvalid = 0;
        expect_item("R3 no effect before done", 0, 64'(model_eff()));
        nvm_done = 1; nvm_crc_ok = crc; step();
        nvm_done = 0; nvm_crc_ok = 0;
        if (nw == NVM_WORDS && crc) begin m_nmask = mask; m_nvm = img; end
        else begin m_nmask = '0; m_nvm = '0; end
        step();
    endtask

    task automatic drv_write(int f, logic [47:0] d);
        drv_wr = 1; drv_fsel = FSEL_W'(f); drv_wdata = d; step(); drv_wr = 0;
        for (int b = 0; b < FLD_W[f]; b++) m_drv[FLD_LSB[f] + b] = d[b];
        m_dmask[f] = 1'b1;
        step();
    endtask

    task automatic drv_clear(int f);
        drv_clr = 1; drv_fsel = FSEL_W'(f); step(); drv_clr = 0;
        m_dmask[f] = 1'b0;
        step();
    endtask

    initial begin
        logic [CFG_W-1:0] s1, s2, img;
        logic [47:0] m1, m2, m3, mac_before;
        m1 = 48'h0211_2233_4455; m2 = 48'h0266_7788_99AA; m3 = 48'h02DE_ADBE_EF01;
        s1 = mk(48'h00AA_BBCC_0001, 2'd0, 0, 0, 1, 0, 1, 0);
        s2 = mk(48'h00AA_BBCC_0002, 2'd1, 1, 1, 0, 1, 0, 1);
        img = mk(m1, 2'd3, 1, 0, 0, 0, 0, 1);

        // Reset state
        hard_reset(s1);
        expect_item("R2 reset eff equals strap", 0, 64'(s1));
        expect_item("R9 strap readback", 1, 64'(s1));
        expect_item("R9 status after reset", 2, 64'd0);
        expect_item("R9 nvm mask after reset", 3, 64'd0);
        expect_item("R9 drv mask after reset", 4, 64'd0);
        expect_item("R8 count after reset", 5, 64'd0);
        expect_item("R7 no pending after reset", 6, 64'd0);
        step();

        // Strap pins move after release
        strap_i = s2; step(); step();
        expect_item("R2 strap ignored after release", 1, 64'(s1));
        expect_item("R2 eff unchanged by strap pins", 0, 64'(s1));
        step();

        // Good load: only ifm and mac valid
        nvm_load(8'h81, img, 4, 1);
        expect_item("R3 R1 good load per-field", 0, 64'(model_eff()));
        expect_item("R9 status good", 2, 64'b011);
        expect_item("R9 nvm mask", 3, 64'h81);
        expect_item("R8 first departure counted", 5, 64'd1);
        step();

        // Driver overrides and clear
        drv_write(7, m2);
        expect_item("R1 driver mac over nvm", 8, 64'(m2));
        drv_write(6, 48'd2);
        expect_item("R5 driver led", 0, 64'(model_eff()));
        expect_item("R9 drv mask", 4, 64'hC0);
        drv_clear(7);
        expect_item("R5 clear falls back to nvm mac", 8, 64'(m1));
        expect_item("R5 drv mask after clear", 4, 64'h40);
        step();

        // Mode change while busy
        dp_idle = 0;
        drv_write(0, 48'd0);
        expect_item("R7 pending while busy", 6, 64'd1);
        expect_item("R7 mode held while busy", 7, 64'd1);
        repeat (3) step();
        expect_item("R7 mode still held", 7, 64'd1);
        dp_idle = 1; step();
        expect_item("R7 mode applied on idle", 7, 64'd0);
        expect_item("R7 pending cleared", 6, 64'd0);
        expect_item("R1 full eff after apply", 0, 64'(model_eff()));
        expect_item("R8 one count per epoch", 5, 64'd1);
        step();

        // Failed loads
        nvm_load(8'h81, img, 4, 0);
        expect_item("R4 bad crc status", 2, 64'b101);
        expect_item("R4 bad crc discards", 3, 64'h00);
        expect_item("R4 strap mac back", 0, 64'(model_eff()));
        nvm_load(8'h81, img, 3, 1);
        expect_item("R4 short load status", 2, 64'b110);
        expect_item("R4 short load discards", 0, 64'(model_eff()));
        nvm_load(8'h81, img, 4, 1);
        expect_item("R4 error sticky after good load", 2, 64'b111);
        expect_item("R1 driver ifm over nvm", 0, 64'(model_eff()));
        step();

        // Soft resets
        soft_reset(s2);
        expect_item("R2 strap relatched on soft reset", 1, 64'(s2));
        expect_item("R6 drv kept on soft reset", 4, 64'h41);
        expect_item("R6 nvm cleared on soft reset", 3, 64'h00);
        expect_item("R4 error kept on soft reset", 2, 64'b100);
        expect_item("R6 eff after soft reset", 0, 64'(model_eff()));
        expect_item("R8 new epoch counted", 5, 64'd2);
        step();
        soft_reset(s2);
        expect_item("R8 third epoch", 5, 64'd3);
        step();
        soft_reset(s2);
        expect_item("R8 saturates", 5, 64'd3);
        step();

        // Hard reset clears everything
        hard_reset(s1);
        expect_item("R6 drv cleared on hard reset", 4, 64'h00);
        expect_item("R4 error cleared on hard reset", 2, 64'b000);
        expect_item("R8 count cleared on hard reset", 5, 64'd0);
        expect_item("R6 eff equals strap", 0, 64'(s1));
        step();

        // MAC stability across soft reset
        nvm_load(8'h80, img, 4, 1);
        mac_before = eff_mac;
        expect_item("R10 mac from nvm", 8, 64'(m1));
        soft_reset(s1);
        nvm_load(8'h80, img, 4, 1);
        expect_item("R10 mac same after soft reset", 8, 64'(mac_before));
        expect_item("R10 full eff after reload", 0, 64'(model_eff()));
        drv_write(7, m3);
        soft_reset(s1);
        expect_item("R10 driver mac kept across soft reset", 8, 64'(m3));
        step(); step();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule